// File: doc/BRIEF.md
# ADC Conversion Sequencer with 64-bit Block Packing

This block runs an external eight-channel, 8-bit successive-approximation converter. The converter has four control pins: an address strobe, a start pulse, a busy/done flag and a read enable. For each sample the sequencer latches a channel number and pulses the address strobe. It then pulses start, so that the conversion begins on start's falling edge. Next it waits for the done flag to drop, which shows that the conversion has begun, and then for the flag to rise again, which shows that it has finished. Finally it enables the converter's output and captures the byte.

Eight captured bytes form one 64-bit word for a block cipher that follows. The first byte of a word goes to the most significant byte. When the eighth byte is stored, the word is presented on the output together with a single-cycle valid strobe. The word stays on the output until the next word replaces it.

Each wait on the done flag has a cycle limit, so a converter that hangs cannot stall the sequencer. If the flag does not change within the limit, the sequencer drops the sample and starts over from its idle step. One conversion takes about 100 µs, and the default limit sits above that at the intended clock.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, adc_ale, adc_start, adc_oe and blk_valid are 0 and blk_data is all zeros.
- R2: After one idle cycle, adc_ale is high for exactly one cycle. adc_start is high for exactly the next cycle.
- R3: From the cycle after adc_start, the sequencer holds (adc_oe, adc_ale and adc_start all low) for as long as adc_eoc is sampled high. It moves on at the first clock edge that samples adc_eoc low.
- R4: After that, it holds for as long as adc_eoc is sampled low. Once a clock edge samples adc_eoc high, adc_oe is high for the next two cycles and then low.
- R5: adc_addr takes the value of chan_sel sampled at the clock edge that leaves the idle cycle. It keeps that value from the adc_ale cycle through the last adc_oe cycle, even if chan_sel changes.
- R6: adc_data is captured at the clock edge that ends the second adc_oe cycle. Eight captures make one word. The first capture lands in blk_data[63:56] and the eighth in blk_data[7:0].
- R7: blk_valid is high for exactly one cycle: the cycle right after the eighth capture's second adc_oe cycle, when blk_data already shows the new word.
- R8: If a wait state lasts WAIT_LIMIT cycles without its exit condition, the sequencer returns to idle and then to adc_ale, with no adc_oe and no capture. A condition seen in the last allowed cycle still advances it. An abandoned sample is not counted in the word.
- R9: blk_data changes only in the cycle where blk_valid is high.
- R10: At most one of adc_ale, adc_start and adc_oe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_sel | input | 3 | Channel number for the next conversion |
| adc_addr | output | 3 | Channel address to the converter |
| adc_ale | output | 1 | Address latch strobe |
| adc_start | output | 1 | Conversion start pulse; conversion begins on its falling edge |
| adc_eoc | input | 1 | Converter flag: high when idle or done, low while converting |
| adc_oe | output | 1 | Converter output enable |
| adc_data | input | 8 | Converter result byte |
| blk_data | output | 64 | Packed word of eight samples, first sample in the top byte |
| blk_valid | output | 1 | One-cycle strobe that marks a new word |

## Verification
Every result has a fixed delay in cycles from the stimulus that causes it. adc_ale comes one cycle after the idle cycle and adc_start one cycle after that. A change on adc_eoc takes effect at the next edge. adc_oe appears one cycle after adc_eoc is seen high and lasts two cycles. blk_valid and the new blk_data come three cycles after adc_eoc is seen high. A timeout fires WAIT_LIMIT cycles after the wait state is entered. The bench changes inputs on falling edges and counts falling edges to find the exact cycle each result is due. It checks the outputs there and also in the cycles on either side. Wait lengths of zero and of exactly WAIT_LIMIT are both tested, so the timeout is checked at its boundary.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Step codes of the conversion sequence, in the order they run.
    typedef enum logic [2:0] {
        SEQ_IDLE       = 3'd0,
        SEQ_ADDR       = 3'd1,
        SEQ_KICK       = 3'd2,
        SEQ_WAIT_BEGIN = 3'd3,
        SEQ_WAIT_DONE  = 3'd4,
        SEQ_READ       = 3'd5,
        SEQ_CAPTURE    = 3'd6
    } seq_state_e;

    // Pin-level controls decoded from the current step.
    typedef struct packed {
        logic addr_en;
        logic kick;
        logic read_en;
        logic capture;
    } pin_ctrl_t;

    function automatic pin_ctrl_t ctrl_of(input seq_state_e s);
        pin_ctrl_t c;
        c = '0;
        case (s)
            SEQ_ADDR:    c.addr_en = 1'b1;
            SEQ_KICK:    c.kick    = 1'b1;
            SEQ_READ:    c.read_en = 1'b1;
            SEQ_CAPTURE: begin
                c.read_en = 1'b1;
                c.capture = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic in_wait(input seq_state_e s);
        return (s == SEQ_WAIT_BEGIN) || (s == SEQ_WAIT_DONE);
    endfunction

endpackage

// File: rtl/adc_seq_wdog.sv
module adc_seq_wdog #(
    parameter int LIMIT = 40000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic restart,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Counts cycles spent in one wait step; cleared on any step change.
    always_ff @(posedge clk) begin
        if (rst || !arm || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = arm && (cnt_q == LAST);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            eoc,
    input  logic            expired,
    input  logic [CH_W-1:0] chan_sel,
    output seq_state_e      state,
    output logic [CH_W-1:0] addr,
    output logic            moving
);
    seq_state_e state_q, state_nxt;
    logic [CH_W-1:0] addr_q;

    always_comb begin
        state_nxt = state_q;
        case (state_q)
            SEQ_IDLE:       state_nxt = SEQ_ADDR;
            SEQ_ADDR:       state_nxt = SEQ_KICK;
            SEQ_KICK:       state_nxt = SEQ_WAIT_BEGIN;
            SEQ_WAIT_BEGIN: begin
                if (!eoc)         state_nxt = SEQ_WAIT_DONE;
                else if (expired) state_nxt = SEQ_IDLE;
            end
            SEQ_WAIT_DONE: begin
                if (eoc)          state_nxt = SEQ_READ;
                else if (expired) state_nxt = SEQ_IDLE;
            end
            SEQ_READ:       state_nxt = SEQ_CAPTURE;
            SEQ_CAPTURE:    state_nxt = SEQ_IDLE;
            default:        state_nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Channel is taken once per sample, in the idle step, then frozen.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (state_q == SEQ_IDLE) begin
            addr_q <= chan_sel;
        end
    end

    assign state  = state_q;
    assign addr   = addr_q;
    assign moving = (state_nxt != state_q);

endmodule

// File: rtl/adc_seq_pack.sv
module adc_seq_pack #(
    parameter int SMP_W = 8,
    parameter int BLK_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [SMP_W-1:0] smp,
    output logic [BLK_W-1:0] blk,
    output logic             blk_vld
);
    localparam int N_SMP = BLK_W / SMP_W;
    localparam int IDX_W = (N_SMP > 1) ? $clog2(N_SMP) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SMP - 1);

    logic [IDX_W-1:0] idx_q;
    logic [BLK_W-1:0] word_nxt;
    logic [BLK_W-1:0] blk_q;
    logic             vld_q;

    // One holding lane per earlier sample; lane 0 feeds the top byte.
    for (genvar g = 0; g < N_SMP - 1; g++) begin : g_lane
        logic [SMP_W-1:0] held_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                held_q <= '0;
            end else if (capture && (idx_q == IDX_W'(g))) begin
                held_q <= smp;
            end
        end
        assign word_nxt[BLK_W-1-g*SMP_W -: SMP_W] = held_q;
    end

    // The final sample goes straight into the bottom byte.
    assign word_nxt[SMP_W-1:0] = smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            blk_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (capture) begin
                if (idx_q == LAST_IDX) begin
                    idx_q <= '0;
                    blk_q <= word_nxt;
                    vld_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign blk     = blk_q;
    assign blk_vld = vld_q;

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int N_CH       = 8,
    parameter int SMP_W      = 8,
    parameter int BLK_W      = 64,
    parameter int WAIT_LIMIT = 40000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(N_CH)-1:0]  chan_sel,
    output logic [$clog2(N_CH)-1:0]  adc_addr,
    output logic                     adc_ale,
    output logic                     adc_start,
    input  logic                     adc_eoc,
    output logic                     adc_oe,
    input  logic [SMP_W-1:0]         adc_data,
    output logic [BLK_W-1:0]         blk_data,
    output logic                     blk_valid
);
    localparam int CH_W = $clog2(N_CH);

    seq_state_e seq_state;
    pin_ctrl_t  ctrl;
    logic       tmo_expired;
    logic       seq_moving;

    adc_seq_fsm #(
        .CH_W (CH_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .eoc      (adc_eoc),
        .expired  (tmo_expired),
        .chan_sel (chan_sel),
        .state    (seq_state),
        .addr     (adc_addr),
        .moving   (seq_moving)
    );

    adc_seq_wdog #(
        .LIMIT (WAIT_LIMIT)
    ) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .arm     (in_wait(seq_state)),
        .restart (seq_moving),
        .expired (tmo_expired)
    );

    assign ctrl      = ctrl_of(seq_state);
    assign adc_ale   = ctrl.addr_en;
    assign adc_start = ctrl.kick;
    assign adc_oe    = ctrl.read_en;

    adc_seq_pack #(
        .SMP_W (SMP_W),
        .BLK_W (BLK_W)
    ) u_pack (
        .clk     (clk),
        .rst     (rst),
        .capture (ctrl.capture),
        .smp     (adc_data),
        .blk     (blk_data),
        .blk_vld (blk_valid)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int CH_W  = 3,
    parameter int BLK_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic [CH_W-1:0]  adc_addr,
    input logic             adc_ale,
    input logic             adc_start,
    input logic             adc_eoc,
    input logic             adc_oe,
    input logic [BLK_W-1:0] blk_data,
    input logic             blk_valid
);
    assert_ctrl_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({adc_ale, adc_start, adc_oe}));

    assert_ale_then_start_R2: assert property (@(posedge clk) disable iff (rst)
        adc_ale |=> (adc_start && !adc_ale));

    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> (!adc_start && !adc_oe));

    assert_addr_held_R5: assert property (@(posedge clk) disable iff (rst)
        (adc_ale || adc_start || adc_oe) |=> $stable(adc_addr));

    assert_oe_after_done_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_oe) |-> $past(adc_eoc));

    assert_oe_two_cycles_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_oe) |=> adc_oe);

    assert_oe_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (adc_oe && $past(adc_oe)) |=> !adc_oe);

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        blk_valid |=> !blk_valid);

    assert_valid_after_read_R7: assert property (@(posedge clk) disable iff (rst)
        blk_valid |-> ($past(adc_oe) && !adc_oe));

    assert_word_held_R9: assert property (@(posedge clk) disable iff (rst)
        !blk_valid |-> $stable(blk_data));

endmodule

bind adc_seq_top adc_seq_chk #(
    .CH_W  (CH_W),
    .BLK_W (BLK_W)
) u_adc_seq_chk (
    .clk       (clk),
    .rst       (rst),
    .adc_addr  (adc_addr),
    .adc_ale   (adc_ale),
    .adc_start (adc_start),
    .adc_eoc   (adc_eoc),
    .adc_oe    (adc_oe),
    .blk_data  (blk_data),
    .blk_valid (blk_valid)
);

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;

    localparam int TB_LIMIT = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  chan_sel = 3'd0;
    logic [2:0]  adc_addr;
    logic        adc_ale;
    logic        adc_start;
    logic        adc_eoc = 1'b1;
    logic        adc_oe;
    logic [7:0]  adc_data = 8'h00;
    logic [63:0] blk_data;
    logic        blk_valid;

    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;
    logic [63:0] exp_word  = '0;
    logic [63:0] last_word = '0;
    int          n_smp     = 0;

    always #2 clk = ~clk;

    adc_seq_top #(
        .N_CH       (8),
        .SMP_W      (8),
        .BLK_W      (64),
        .WAIT_LIMIT (TB_LIMIT)
    ) i_adc_seq_top (
        .clk       (clk),
        .rst       (rst),
        .chan_sel  (chan_sel),
        .adc_addr  (adc_addr),
        .adc_ale   (adc_ale),
        .adc_start (adc_start),
        .adc_eoc   (adc_eoc),
        .adc_oe    (adc_oe),
        .adc_data  (adc_data),
        .blk_data  (blk_data),
        .blk_valid (blk_valid)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Starts and ends on the falling edge of an idle cycle.
    task automatic run_sample(input logic [2:0] ch, input logic [7:0] d,
                              input int hold_hi, input int hold_lo);
        chan_sel = ch;
        @(negedge clk);
        chk(adc_ale == 1'b1 && adc_start == 1'b0, "R2/R8", "ale after idle", {62'd0, adc_ale, adc_start}, 64'h2);
        chk(adc_addr == ch, "R5", "addr at ale", {61'd0, adc_addr}, {61'd0, ch});
        chk(blk_valid == 1'b0, "R7", "valid low at ale", {63'd0, blk_valid}, 64'd0);
        chan_sel = ~ch;
        @(negedge clk);
        chk(adc_start == 1'b1 && adc_ale == 1'b0, "R2", "start after ale", {62'd0, adc_ale, adc_start}, 64'h1);
        chk(adc_addr == ch, "R5", "addr at start", {61'd0, adc_addr}, {61'd0, ch});
        @(negedge clk);
        chk(!adc_start && !adc_oe && !adc_ale, "R3", "quiet after start", {61'd0, adc_ale, adc_start, adc_oe}, 64'd0);
        for (int i = 0; i < hold_hi; i++) begin
            @(negedge clk);
            chk(!adc_oe && !adc_ale && !adc_start, "R3", "hold while eoc high", {61'd0, adc_ale, adc_start, adc_oe}, 64'd0);
        end
        adc_eoc = 1'b0;
        @(negedge clk);
        chk(!adc_oe && !adc_ale, "R4", "no read at conversion begin", {62'd0, adc_ale, adc_oe}, 64'd0);
        for (int i = 0; i < hold_lo; i++) begin
            @(negedge clk);
            chk(!adc_oe && !adc_ale, "R4", "hold while eoc low", {62'd0, adc_ale, adc_oe}, 64'd0);
            chk(adc_addr == ch, "R5", "addr during conversion", {61'd0, adc_addr}, {61'd0, ch});
        end
        adc_eoc  = 1'b1;
        adc_data = d;
        @(negedge clk);
        chk(adc_oe == 1'b1, "R4", "oe first cycle", {63'd0, adc_oe}, 64'd1);
        @(negedge clk);
        chk(adc_oe == 1'b1, "R4", "oe second cycle", {63'd0, adc_oe}, 64'd1);
        chk(adc_addr == ch, "R5", "addr at read", {61'd0, adc_addr}, {61'd0, ch});
        @(negedge clk);
        adc_data = ~d;
        chk(adc_oe == 1'b0, "R4", "oe off after two cycles", {63'd0, adc_oe}, 64'd0);
        exp_word = {exp_word[55:0], d};
        n_smp++;
        if (n_smp == 8) begin
            chk(blk_valid == 1'b1, "R7", "valid after eighth sample", {63'd0, blk_valid}, 64'd1);
            chk(blk_data == exp_word, "R6", "packed word", blk_data, exp_word);
            last_word = exp_word;
            n_smp = 0;
        end else begin
            chk(blk_valid == 1'b0, "R7", "no valid mid word", {63'd0, blk_valid}, 64'd0);
            chk(blk_data == last_word, "R9", "word held", blk_data, last_word);
        end
    endtask

    // Lets one wait step expire; stage 0 = eoc never drops, 1 = never returns.
    task automatic run_timeout(input logic [2:0] ch, input int stage);
        chan_sel = ch;
        @(negedge clk);
        chk(adc_ale == 1'b1, "R8", "ale before timeout", {63'd0, adc_ale}, 64'd1);
        @(negedge clk);
        @(negedge clk);
        if (stage == 1) begin
            adc_eoc = 1'b0;
            @(negedge clk);
        end
        for (int i = 0; i < TB_LIMIT; i++) begin
            @(negedge clk);
            chk(!adc_oe && !adc_ale && !adc_start && !blk_valid, "R8", "silent until timeout",
                {60'd0, adc_ale, adc_start, adc_oe, blk_valid}, 64'd0);
        end
        adc_eoc = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!adc_ale && !adc_start && !adc_oe && !blk_valid, "R1", "controls in reset",
            {60'd0, adc_ale, adc_start, adc_oe, blk_valid}, 64'd0);
        chk(blk_data == 64'd0, "R1", "word in reset", blk_data, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_plain_word();
        for (int k = 0; k < 8; k++) begin
            run_sample(3'(k), 8'(8'h10 * k + 8'h0F - k), k, 7 - k);
        end
    endtask

    task automatic t_timeouts_and_bounds();
        run_sample(3'd5, 8'hA5, TB_LIMIT - 1, 0);
        run_timeout(3'd2, 0);
        run_sample(3'd2, 8'h3C, 0, TB_LIMIT - 1);
        run_timeout(3'd6, 1);
        run_sample(3'd6, 8'hFF, 3, 3);
        run_sample(3'd1, 8'h00, 0, 0);
        run_timeout(3'd7, 1);
        run_sample(3'd7, 8'h81, 1, 2);
        run_sample(3'd0, 8'h5A, 2, 1);
        run_timeout(3'd4, 0);
        run_sample(3'd4, 8'hC3, TB_LIMIT - 1, TB_LIMIT - 1);
        run_sample(3'd3, 8'h7E, 5, 6);
    endtask

    initial begin
        t_reset();
        t_plain_word();
        t_timeouts_and_bounds();
        @(negedge clk);
        chk(blk_valid == 1'b0, "R7", "valid single cycle", {63'd0, blk_valid}, 64'd0);
        chk(blk_data == last_word, "R9", "word held after valid", blk_data, last_word);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule